// File: doc/BRIEF.md
# Interrupt Pin to Message Dispatcher

The dispatcher watches a group of interrupt input pins and turns each new assertion of a pin into one or more interrupt messages. Every pin has a redirection entry, supplied as a packed configuration word, that holds the destination, the vector, the delivery mode, the destination mode, the level, the trigger mode and a mask bit. A rising edge on a pin is remembered as a pending event. A small state machine serves the pending events one at a time and presents the messages on a valid/ready port.

In physical destination mode a pin event yields exactly one message addressed to the destination field. In logical destination mode the 8-bit destination is a bitmask, and the block sends one message per set bit, lowest bit first. For the external-interrupt delivery mode the vector comes from a separate input that an external legacy controller drives. Entries with a reserved delivery mode send nothing and set a sticky error flag instead.

The state machine has three states. `ST_IDLE` waits for a pending pin. It takes the lowest-numbered one and moves to `ST_SINGLE` for a physical entry, or to `ST_FANOUT` for a logical entry with a non-zero bitmask. It stays in `ST_IDLE` when the entry is masked, has a reserved mode, or has an empty bitmask. `ST_SINGLE` returns to `ST_IDLE` when its one message is accepted. `ST_FANOUT` clears the bit it has just sent on each accepted message and returns to `ST_IDLE` when no bits are left.

Top module: `pin_msg_dispatch`

## Requirements
- R1: A message sequence starts only on a low-to-high transition of a pin. Holding the pin high produces nothing more. A fall followed by a new rise produces a new sequence.
- R2: If the served pin's entry has its mask bit (entry bit 14) set, the event is dropped and no message appears.
- R3: When the entry's delivery mode (bits 10:8) is 3'b111, the message vector equals `ext_vector`. Otherwise it equals the entry's vector field (bits 7:0).
- R4: Each message copies the delivery mode, the destination mode (bit 11), the level (bit 12) and the trigger mode (bit 13) from the entry.
- R5: With destination mode 0, exactly one message is sent, and its destination equals the entry's destination field (bits 22:15).
- R6: With destination mode 1, one message is sent for each set bit of the destination field, in ascending bit order, and each message's destination is that bit's index.
- R7: Delivery modes 3'b011 and 3'b110 produce no message and set `err_reserved`, which stays high until reset.
- R8: When several pins are pending, the lowest-numbered pin is served first. A fanout completes before the next pin is served.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and all message fields hold their values.
- R10: A logical-mode entry whose destination field is zero produces no message, and the block returns to idle.
- R11: After reset, `msg_valid` and `err_reserved` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt pins, active high |
| pin_cfg | input | NUM_PINS*23 | Redirection entries; pin i occupies bits [i*23 +: 23] |
| ext_vector | input | 8 | Vector from the external legacy controller |
| msg_ready | input | 1 | Consumer accepts the current message |
| msg_valid | output | 1 | A message is presented |
| msg_dest | output | 8 | Destination ID of the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_dest_mode | output | 1 | Destination mode, 0 physical, 1 logical |
| msg_level | output | 1 | Level, copied from the entry |
| msg_trigger | output | 1 | Trigger mode, copied from the entry |
| err_reserved | output | 1 | Sticky flag: a reserved delivery mode was served |

## Verification
A table drives single-pin events through physical entries, logical bitmasks with sparse bits and with both edge bits set, the external-vector mode, a masked entry and an empty bitmask. Together these rows separate the one-message path from the fanout path, the entry vector from the external vector, and dropped events from sent ones. Directed cases hold a pin high and then pulse it again, raise two pins in the same cycle to expose the service order, stall the consumer in the middle of a message, and serve both reserved modes to show that the error flag sets and stays set.

// File: rtl/pin_msg_pkg.sv
package pin_msg_pkg;

    localparam int ENTRY_W = 23;
    localparam int VEC_W   = 8;
    localparam int DEST_W  = 8;

    localparam logic [2:0] MODE_EXTERNAL = 3'b111;
    localparam logic [2:0] MODE_RSVD_A   = 3'b011;
    localparam logic [2:0] MODE_RSVD_B   = 3'b110;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;
        logic              lvl;
        logic              dmode;
        logic [2:0]        mode;
        logic [VEC_W-1:0]  vec;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_FANOUT = 2'd2
    } disp_state_t;

    function automatic logic mode_is_reserved(input logic [2:0] m);
        return (m == MODE_RSVD_A) || (m == MODE_RSVD_B);
    endfunction

endpackage

// File: rtl/pin_edge_capture.sv
module pin_edge_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pin_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = pin & ~pin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            pend_q <= '0;
        end else begin
            pin_q  <= pin;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/pin_msg_dispatch.sv
module pin_msg_dispatch
    import pin_msg_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PIN_IW  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int BIT_IW  = $clog2(DEST_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         pin_in,
    input  logic [NUM_PINS*ENTRY_W-1:0] pin_cfg,
    input  logic [VEC_W-1:0]            ext_vector,
    input  logic                        msg_ready,
    output logic                        msg_valid,
    output logic [DEST_W-1:0]           msg_dest,
    output logic [VEC_W-1:0]            msg_vector,
    output logic [2:0]                  msg_mode,
    output logic                        msg_dest_mode,
    output logic                        msg_level,
    output logic                        msg_trigger,
    output logic                        err_reserved
);
    disp_state_t state_q, state_d;
    entry_t      cur_q, cur_d;
    logic [VEC_W-1:0]  vec_q, vec_d;
    logic [DEST_W-1:0] rem_q, rem_d;
    logic              err_q, err_d;

    entry_t ent [NUM_PINS];
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
        assign ent[g] = pin_cfg[g*ENTRY_W +: ENTRY_W];
    end

    logic [NUM_PINS-1:0] pend, clr;
    logic                win_any;
    logic [PIN_IW-1:0]   win_idx;
    logic                rem_any;
    logic [BIT_IW-1:0]   bit_idx;
    entry_t              sel;
    logic                fire;
    logic                fanout_active;

    pin_edge_capture #(.N(NUM_PINS)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .pin (pin_in),
        .clr (clr),
        .pend (pend)
    );

    lowest_pick #(.W(NUM_PINS)) u_pin_pick (
        .req (pend),
        .any (win_any),
        .idx (win_idx)
    );

    lowest_pick #(.W(DEST_W)) u_bit_pick (
        .req (rem_q),
        .any (rem_any),
        .idx (bit_idx)
    );

    assign sel  = ent[win_idx];
    assign fire = msg_valid && msg_ready;
    assign fanout_active = (state_q == ST_FANOUT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            vec_q   <= '0;
            rem_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            vec_q   <= vec_d;
            rem_q   <= rem_d;
            err_q   <= err_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        vec_d   = vec_q;
        rem_d   = rem_q;
        err_d   = err_q;
        clr     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) begin
                    clr   = NUM_PINS'(1) << win_idx;
                    cur_d = sel;
                    vec_d = (sel.mode == MODE_EXTERNAL) ? ext_vector : sel.vec;
                    rem_d = sel.dest;
                    if (sel.mask) begin
                        state_d = ST_IDLE;
                    end else if (mode_is_reserved(sel.mode)) begin
                        err_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!sel.dmode) begin
                        state_d = ST_SINGLE;
                    end else if (sel.dest != '0) begin
                        state_d = ST_FANOUT;
                    end
                end
            end
            ST_SINGLE: begin
                if (fire) state_d = ST_IDLE;
            end
            ST_FANOUT: begin
                if (fire) begin
                    rem_d = rem_q & ~(DEST_W'(1) << bit_idx);
                    if ((rem_q & ~(DEST_W'(1) << bit_idx)) == '0) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        msg_valid     = (state_q != ST_IDLE);
        msg_dest      = fanout_active ? DEST_W'(bit_idx) : cur_q.dest;
        msg_vector    = vec_q;
        msg_mode      = cur_q.mode;
        msg_dest_mode = cur_q.dmode;
        msg_level     = cur_q.lvl;
        msg_trigger   = cur_q.trig;
        err_reserved  = err_q;
    end

endmodule

module pin_msg_dispatch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic [7:0] msg_dest,
    input logic [7:0] msg_vector,
    input logic [2:0] msg_mode,
    input logic       msg_dest_mode,
    input logic       msg_level,
    input logic       msg_trigger,
    input logic       err_reserved,
    input logic       fanout_active
);
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_vector)
            && $stable(msg_mode) && $stable(msg_dest_mode) && $stable(msg_level)
            && $stable(msg_trigger)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_reserved |=> err_reserved);

    assert_no_reserved_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_mode != 3'b011 && msg_mode != 3'b110));

    assert_fanout_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && fanout_active) |=>
            (!fanout_active || (msg_dest > $past(msg_dest))));
endmodule

bind pin_msg_dispatch pin_msg_dispatch_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_dest      (msg_dest),
    .msg_vector    (msg_vector),
    .msg_mode      (msg_mode),
    .msg_dest_mode (msg_dest_mode),
    .msg_level     (msg_level),
    .msg_trigger   (msg_trigger),
    .err_reserved  (err_reserved),
    .fanout_active (fanout_active)
);

// File: tb/pin_msg_dispatch_tb.sv
module pin_msg_dispatch_tb;
    localparam int NP = 8;
    localparam int EW = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NP*EW-1:0] pin_cfg;
    logic [7:0] ext_vector = 8'h9C;
    logic msg_ready = 1'b1;
    logic msg_valid, msg_dest_mode, msg_level, msg_trigger, err_reserved;
    logic [7:0] msg_dest, msg_vector;
    logic [2:0] msg_mode;

    logic [EW-1:0] cfg_e [NP];
    always_comb begin
        for (int i = 0; i < NP; i++) pin_cfg[i*EW +: EW] = cfg_e[i];
    end

    always #2.5 clk = ~clk;

    pin_msg_dispatch #(.NUM_PINS(NP)) u_dut (
        .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .pin_cfg (pin_cfg),
        .ext_vector (ext_vector), .msg_ready (msg_ready), .msg_valid (msg_valid),
        .msg_dest (msg_dest), .msg_vector (msg_vector), .msg_mode (msg_mode),
        .msg_dest_mode (msg_dest_mode), .msg_level (msg_level),
        .msg_trigger (msg_trigger), .err_reserved (err_reserved)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // entry word: {dest, mask, trig, lvl, dmode, mode, vec}
    localparam logic [EW-1:0] MASKED = {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00};

    typedef struct packed {
        logic [2:0]    pin;
        logic [EW-1:0] ent;
        logic [3:0]    cnt;
        logic [63:0]   dsts;
        logic [7:0]    vec;
    } row_t;

    localparam row_t ROWS [7] = '{
        '{3'd2, {8'h05, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h41}, 4'd1, 64'h05, 8'h41},
        '{3'd5, {8'hA4, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 8'h30}, 4'd3, 64'h07_05_02, 8'h30},
        '{3'd0, {8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 8'h11}, 4'd1, 64'h0F, 8'h9C},
        '{3'd7, {8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h22}, 4'd0, 64'h00, 8'h22},
        '{3'd3, {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h23}, 4'd0, 64'h00, 8'h23},
        '{3'd1, {8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 3'b010, 8'h57}, 4'd2, 64'h07_00, 8'h57},
        '{3'd6, {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'b100, 8'h66}, 4'd1, 64'hFF, 8'h66}
    };

    int got_n;
    logic [7:0] got_dest [16];
    logic [7:0] got_vec [16];
    logic [2:0] got_mode [16];
    logic got_dm [16], got_lvl [16], got_trg [16];

    // call right after a negedge
    task automatic collect(input int cycles);
        got_n = 0;
        for (int c = 0; c < cycles; c++) begin
            if (msg_valid && msg_ready && got_n < 16) begin
                got_dest[got_n] = msg_dest;
                got_vec[got_n]  = msg_vector;
                got_mode[got_n] = msg_mode;
                got_dm[got_n]   = msg_dest_mode;
                got_lvl[got_n]  = msg_level;
                got_trg[got_n]  = msg_trigger;
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic mask_all();
        for (int i = 0; i < NP; i++) cfg_e[i] = MASKED;
    endtask

    initial begin
        mask_all();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(msg_valid == 1'b0, "R11 valid after reset", msg_valid, 0);
        chk(err_reserved == 1'b0, "R11 err after reset", err_reserved, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6 R10
        for (int r = 0; r < 7; r++) begin
            mask_all();
            cfg_e[ROWS[r].pin] = ROWS[r].ent;
            pin_in[ROWS[r].pin] = 1'b1;
            collect(30);
            chk(got_n == int'(ROWS[r].cnt), $sformatf("R2/R5/R6/R10 row %0d count", r),
                got_n, int'(ROWS[r].cnt));
            for (int k = 0; k < got_n && k < int'(ROWS[r].cnt); k++) begin
                chk(got_dest[k] == ROWS[r].dsts[k*8 +: 8], $sformatf("R5/R6 row %0d dest %0d", r, k),
                    got_dest[k], ROWS[r].dsts[k*8 +: 8]);
                chk(got_vec[k] == ROWS[r].vec, $sformatf("R3 row %0d vector", r),
                    got_vec[k], ROWS[r].vec);
                chk({got_mode[k], got_dm[k], got_lvl[k], got_trg[k]} ==
                    {ROWS[r].ent[10:8], ROWS[r].ent[11], ROWS[r].ent[12], ROWS[r].ent[13]},
                    $sformatf("R4 row %0d fields", r),
                    {got_mode[k], got_dm[k], got_lvl[k], got_trg[k]},
                    {ROWS[r].ent[10:8], ROWS[r].ent[11], ROWS[r].ent[12], ROWS[r].ent[13]});
            end
            pin_in = '0;
            repeat (2) @(negedge clk);
        end
        chk(err_reserved == 1'b0, "R7 no error without reserved mode", err_reserved, 0);

        // R1: hold high, then re-pulse
        mask_all();
        cfg_e[2] = ROWS[0].ent;
        pin_in[2] = 1'b1;
        collect(20);
        chk(got_n == 1, "R1 first rise", got_n, 1);
        collect(20);
        chk(got_n == 0, "R1 held high no repeat", got_n, 0);
        pin_in[2] = 1'b0;
        repeat (2) @(negedge clk);
        chk(msg_valid == 1'b0, "R1 fall sends nothing", msg_valid, 0);
        pin_in[2] = 1'b1;
        collect(20);
        chk(got_n == 1, "R1 new rise", got_n, 1);
        pin_in = '0;
        repeat (2) @(negedge clk);

        // R8: pins 4 and 1 rise together; pin 1 fans out to 0,1
        mask_all();
        cfg_e[4] = {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h44};
        cfg_e[1] = {8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h11};
        pin_in[4] = 1'b1;
        pin_in[1] = 1'b1;
        collect(30);
        chk(got_n == 3, "R8 total messages", got_n, 3);
        chk(got_dest[0] == 8'd0 && got_vec[0] == 8'h11, "R8 first from pin1", got_dest[0], 0);
        chk(got_dest[1] == 8'd1 && got_vec[1] == 8'h11, "R8 fanout done before pin4", got_dest[1], 1);
        chk(got_dest[2] == 8'd9 && got_vec[2] == 8'h44, "R8 pin4 last", got_dest[2], 9);
        pin_in = '0;
        repeat (2) @(negedge clk);

        // R9: stall
        mask_all();
        cfg_e[2] = ROWS[0].ent;
        msg_ready = 1'b0;
        pin_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk(msg_valid == 1'b1 && msg_dest == 8'h05, "R9 presented under stall", msg_dest, 5);
        repeat (5) @(negedge clk);
        chk(msg_valid == 1'b1 && msg_dest == 8'h05 && msg_vector == 8'h41,
            "R9 held under stall", msg_vector, 8'h41);
        msg_ready = 1'b1;
        collect(10);
        chk(got_n == 1, "R9 single accept after stall", got_n, 1);
        pin_in = '0;
        repeat (2) @(negedge clk);

        // R7: reserved modes
        mask_all();
        cfg_e[4] = {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'b011, 8'h70};
        cfg_e[6] = {8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110, 8'h71};
        pin_in[4] = 1'b1;
        collect(15);
        chk(got_n == 0, "R7 mode 011 no message", got_n, 0);
        chk(err_reserved == 1'b1, "R7 error set", err_reserved, 1);
        pin_in[6] = 1'b1;
        collect(15);
        chk(got_n == 0, "R7 mode 110 no message", got_n, 0);
        pin_in = '0;
        mask_all();
        cfg_e[2] = ROWS[0].ent;
        pin_in[2] = 1'b1;
        collect(15);
        chk(err_reserved == 1'b1 && got_n == 1, "R7 error sticky", err_reserved, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule